// File: doc/BRIEF.md
# Error Logging and Message Engine for a PCI Express Function

This block records the errors that a non-root PCI Express function detects, either as the receiver or completer of a packet or as the agent that notices a fault on its own. Each cycle it can take one error event: an error code, which is the error's bit position in the status, mask and severity registers, a class flag (correctable or uncorrectable), a default severity and the captured 128-bit packet header. In the same cycle it works out which status bits to set and whether an error message is due.

The block keeps combined device and legacy status bits and a control word of reporting enables. When the advanced-reporting variant is selected, it also keeps correctable and uncorrectable status, mask and severity registers, a first-error pointer and a header log. Software programs the control, mask and severity words and clears status bits by writing ones through a small word-addressed register port. The read path is combinational.

Error messages leave on a valid/ready output that carries a 2-bit message type. A message stays on the output until the consumer accepts it.

Top module: `errrep_engine`

## Requirements
- R1: After reset, every status, mask, severity, control, pointer and log word reads zero and msg_valid is low.
- R2: A correctable event sets device-status bit 0 (address 1) and the bit at the event code in the correctable status word (address 2).
- R3: A correctable event requests ERR_COR only when its bit in the correctable mask (address 3) is clear and control bit 0 (correctable enable, address 0) is set.
- R4: An uncorrectable event takes its severity from its bit in the severity word (address 6, 1 = fatal). It sets device-status bit 2 when fatal and bit 1 when non-fatal.
- R5: An uncorrectable event with code 20 (unsupported request) sets device-status bit 3. Code 12 (poisoned packet) sets bit 4. Code 15 (completer abort) sets bit 5.
- R6: An uncorrectable event always sets its bit in the uncorrectable status word (address 4). When its bit in the uncorrectable mask (address 5) is set, it requests no message, does not set bit 6 and captures nothing.
- R7: An unmasked uncorrectable event that arrives while the uncorrectable status word is zero loads its code into bits 4:0 of address 7. It also copies header dwords 0..3 (evt_hdr[31:0] first) into addresses 9..12. Later events leave both unchanged.
- R8: An unmasked unsupported request requests nothing when control bit 3 is clear. Otherwise it requests ERR_FATAL or ERR_NONFATAL according to its severity. It never sets device-status bit 6.
- R9: Any other unmasked uncorrectable event sets device-status bit 6 when control bit 4 (system-error enable) is set. It requests ERR_FATAL when fatal and control bit 4 or bit 2 is set. It requests ERR_NONFATAL when non-fatal and control bit 4 or bit 1 is set.
- R10: Message types are 00 ERR_COR, 01 ERR_NONFATAL and 11 ERR_FATAL. msg_valid rises the cycle after the event and holds with a stable type until msg_ready. A new request is taken only if no message is outstanding or the outstanding one is accepted in that same cycle; otherwise the new request is dropped.
- R11: Status words at addresses 1, 2 and 4 are write-one-to-clear. A hardware set and a software clear of the same bit in the same cycle leave the bit set.
- R12: Address 8 reads {NEXT_CAP[11:0], 4'h1, 16'h0001}.
- R13: Control bits 4:0 (address 0) and the mask and severity words are read/write. Unused control bits and addresses 13..15 read zero, and events are accepted on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error event strobe, at most one per cycle |
| evt_code | input | CODE_W | Error bit position |
| evt_uncorr | input | 1 | 1 = uncorrectable class |
| evt_fatal_dflt | input | 1 | Default severity, used without advanced reporting |
| evt_hdr | input | 32*HDR_DW | Captured packet header, dword 0 in the low bits |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data (ones clear status bits) |
| reg_rdata | output | 32 | Read data for reg_addr |
| msg_valid | output | 1 | Error message request pending |
| msg_type | output | 2 | Message type code |
| msg_ready | input | 1 | Consumer accepts the message |

## Verification
Any faulty internal state shows up at the ports within a cycle. A stale or wrongly cleared uncorrectable status word changes whether the next unmasked error is captured, which appears in the pointer and log reads right after that event. A wrong mask, severity or enable appears as a missing, extra or mistyped msg_valid one cycle after the event. A broken hold or drop rule appears as msg_type changing under a stalled consumer. The bench keeps a shadow register model, compares the message output after every event, and reads back the whole register space at intervals.

// File: rtl/errrep_pkg.sv
package errrep_pkg;

   localparam int REG_DW = 32;

   // word addresses of the register port
   localparam int A_CTRL  = 0;
   localparam int A_DEV   = 1;
   localparam int A_CSTAT = 2;
   localparam int A_CMASK = 3;
   localparam int A_USTAT = 4;
   localparam int A_UMASK = 5;
   localparam int A_USEV  = 6;
   localparam int A_FEP   = 7;
   localparam int A_CAPH  = 8;
   localparam int A_HLOG  = 9;

   typedef enum logic [1:0] {
      MSG_COR      = 2'b00,
      MSG_NONFATAL = 2'b01,
      MSG_FATAL    = 2'b11
   } msg_kind_e;

   // device / legacy status, bit 0 is cor
   typedef struct packed {
      logic sys_err;
      logic tgt_abort;
      logic parity;
      logic ur;
      logic fatal;
      logic nonfatal;
      logic cor;
   } dev_bits_t;

   // reporting enables, bit 0 is cor_en
   typedef struct packed {
      logic serr_en;
      logic ur_en;
      logic fatal_en;
      logic nonfatal_en;
      logic cor_en;
   } ctrl_t;

endpackage

// File: rtl/errrep_policy.sv
module errrep_policy
   import errrep_pkg::*;
#(
   parameter int ERR_BITS = 32,
   parameter bit HAS_AER  = 1'b1,
   parameter int UR_POS   = 20,
   parameter int PSN_POS  = 12,
   parameter int CA_POS   = 15,
   localparam int CODE_W  = $clog2(ERR_BITS)
) (
   input  logic                evt_valid,
   input  logic [CODE_W-1:0]   evt_code,
   input  logic                evt_uncorr,
   input  logic                evt_fatal_dflt,
   input  ctrl_t               ctrl,
   input  logic [ERR_BITS-1:0] c_mask,
   input  logic [ERR_BITS-1:0] uc_mask,
   input  logic [ERR_BITS-1:0] uc_sev,
   input  logic [ERR_BITS-1:0] uc_stat,
   output dev_bits_t           dev_set,
   output logic [ERR_BITS-1:0] c_set,
   output logic [ERR_BITS-1:0] uc_set,
   output logic                first_hit,
   output logic                msg_req,
   output msg_kind_e           msg_kind
);

   always_comb begin
      logic [ERR_BITS-1:0] hot;
      logic fatal;
      logic masked;
      hot            = '0;
      hot[evt_code]  = 1'b1;
      dev_set        = '0;
      c_set          = '0;
      uc_set         = '0;
      first_hit      = 1'b0;
      msg_req        = 1'b0;
      msg_kind       = MSG_COR;
      fatal          = HAS_AER ? uc_sev[evt_code] : evt_fatal_dflt;
      masked         = 1'b0;
      if (evt_valid && !evt_uncorr) begin
         dev_set.cor = 1'b1;
         if (HAS_AER) c_set = hot;
         masked = HAS_AER && c_mask[evt_code];
         if (!masked && ctrl.cor_en) begin
            msg_req  = 1'b1;
            msg_kind = MSG_COR;
         end
      end else if (evt_valid) begin
         dev_set.fatal     = fatal;
         dev_set.nonfatal  = !fatal;
         dev_set.ur        = (evt_code == CODE_W'(UR_POS));
         dev_set.parity    = (evt_code == CODE_W'(PSN_POS));
         dev_set.tgt_abort = (evt_code == CODE_W'(CA_POS));
         if (HAS_AER) uc_set = hot;
         masked = HAS_AER && uc_mask[evt_code];
         if (!masked) begin
            first_hit = HAS_AER && (uc_stat == '0);
            if (dev_set.ur) begin
               if (ctrl.ur_en) begin
                  msg_req  = 1'b1;
                  msg_kind = fatal ? MSG_FATAL : MSG_NONFATAL;
               end
            end else begin
               dev_set.sys_err = ctrl.serr_en;
               if (fatal && (ctrl.serr_en || ctrl.fatal_en)) begin
                  msg_req  = 1'b1;
                  msg_kind = MSG_FATAL;
               end else if (!fatal && (ctrl.serr_en || ctrl.nonfatal_en)) begin
                  msg_req  = 1'b1;
                  msg_kind = MSG_NONFATAL;
               end
            end
         end
      end
   end

endmodule

// File: rtl/errrep_regs.sv
module errrep_regs
   import errrep_pkg::*;
#(
   parameter int          ERR_BITS = 32,
   parameter int          HDR_DW   = 4,
   parameter int          ADDR_W   = 4,
   parameter bit          HAS_AER  = 1'b1,
   parameter logic [11:0] NEXT_CAP = 12'h000,
   localparam int         CODE_W   = $clog2(ERR_BITS),
   localparam int         NADDR    = 1 << ADDR_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [REG_DW-1:0]        reg_wdata,
   input  dev_bits_t                dev_set,
   input  logic [ERR_BITS-1:0]      c_set,
   input  logic [ERR_BITS-1:0]      uc_set,
   input  logic                     first_hit,
   input  logic [CODE_W-1:0]        first_code,
   input  logic [REG_DW*HDR_DW-1:0] hdr_in,
   output ctrl_t                    ctrl,
   output logic [ERR_BITS-1:0]      c_mask,
   output logic [ERR_BITS-1:0]      uc_mask,
   output logic [ERR_BITS-1:0]      uc_sev,
   output logic [ERR_BITS-1:0]      uc_stat,
   output logic [REG_DW-1:0]        reg_rdata
);

   logic [NADDR-1:0]    wsel;
   logic [6:0]          dev_q;
   logic [ERR_BITS-1:0] c_stat;
   logic [CODE_W-1:0]   fep_q;
   logic [REG_DW-1:0]   hdr_q [HDR_DW];
   logic [REG_DW-1:0]   cap_hdr;
   logic [ERR_BITS-1:0] wd_e;

   assign wsel = reg_wr ? (NADDR'(1) << reg_addr) : '0;
   assign wd_e = reg_wdata[ERR_BITS-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl  <= '0;
         dev_q <= '0;
      end else begin
         if (wsel[A_CTRL]) ctrl <= ctrl_t'(reg_wdata[4:0]);
         dev_q <= (dev_q & ~(wsel[A_DEV] ? reg_wdata[6:0] : 7'd0)) | 7'(dev_set);
      end
   end

   generate
      if (HAS_AER) begin : g_aer
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               c_stat  <= '0;
               c_mask  <= '0;
               uc_stat <= '0;
               uc_mask <= '0;
               uc_sev  <= '0;
               fep_q   <= '0;
            end else begin
               c_stat  <= (c_stat  & ~(wsel[A_CSTAT] ? wd_e : '0)) | c_set;
               uc_stat <= (uc_stat & ~(wsel[A_USTAT] ? wd_e : '0)) | uc_set;
               if (wsel[A_CMASK]) c_mask  <= wd_e;
               if (wsel[A_UMASK]) uc_mask <= wd_e;
               if (wsel[A_USEV])  uc_sev  <= wd_e;
               if (first_hit)     fep_q   <= first_code;
            end
         end
         for (genvar i = 0; i < HDR_DW; i++) begin : g_log
            always_ff @(posedge clk) begin
               if (!rst_n)         hdr_q[i] <= '0;
               else if (first_hit) hdr_q[i] <= hdr_in[REG_DW*i +: REG_DW];
            end
         end
         assign cap_hdr = {NEXT_CAP, 4'h1, 16'h0001};

         // R11: a hardware set survives a same-cycle software clear
         a_r11_uc_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (|uc_set) |=> ((uc_stat & $past(uc_set)) == $past(uc_set)));
         // R7: the header log only moves on a first-error capture
         a_r7_log_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !first_hit |=> ($stable(hdr_q[0]) && $stable(fep_q)));
      end else begin : g_plain
         assign c_stat  = '0;
         assign c_mask  = '0;
         assign uc_stat = '0;
         assign uc_mask = '0;
         assign uc_sev  = '0;
         assign fep_q   = '0;
         for (genvar i = 0; i < HDR_DW; i++) begin : g_log
            assign hdr_q[i] = '0;
         end
         assign cap_hdr = '0;
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      case (int'(reg_addr))
         A_CTRL:  reg_rdata = REG_DW'(ctrl);
         A_DEV:   reg_rdata = REG_DW'(dev_q);
         A_CSTAT: reg_rdata = REG_DW'(c_stat);
         A_CMASK: reg_rdata = REG_DW'(c_mask);
         A_USTAT: reg_rdata = REG_DW'(uc_stat);
         A_UMASK: reg_rdata = REG_DW'(uc_mask);
         A_USEV:  reg_rdata = REG_DW'(uc_sev);
         A_FEP:   reg_rdata = REG_DW'(fep_q);
         A_CAPH:  reg_rdata = cap_hdr;
         default: begin
            for (int i = 0; i < HDR_DW; i++)
               if (int'(reg_addr) == A_HLOG + i) reg_rdata = hdr_q[i];
         end
      endcase
   end

   // R11: device status set wins over clear
   a_r11_dev_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|dev_set) |=> ((dev_q & $past(7'(dev_set))) == $past(7'(dev_set))));

endmodule

// File: rtl/errrep_msg.sv
module errrep_msg
   import errrep_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req,
   input  msg_kind_e kind,
   input  logic      msg_ready,
   output logic      msg_valid,
   output logic [1:0] msg_type
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_type  <= MSG_COR;
      end else if (req && (!msg_valid || msg_ready)) begin
         msg_valid <= 1'b1;
         msg_type  <= kind;
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end

   // R10: an unaccepted message stays put
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_type)));
   // R10: only the three defined type codes appear
   a_r10_legal_type: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (msg_type != 2'b10));

endmodule

// File: rtl/errrep_engine.sv
module errrep_engine
   import errrep_pkg::*;
#(
   parameter int          ERR_BITS = 32,
   parameter int          HDR_DW   = 4,
   parameter int          ADDR_W   = 4,
   parameter bit          HAS_AER  = 1'b1,
   parameter logic [11:0] NEXT_CAP = 12'h140,
   parameter int          UR_POS   = 20,
   parameter int          PSN_POS  = 12,
   parameter int          CA_POS   = 15,
   localparam int         CODE_W   = $clog2(ERR_BITS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     evt_valid,
   input  logic [CODE_W-1:0]        evt_code,
   input  logic                     evt_uncorr,
   input  logic                     evt_fatal_dflt,
   input  logic [32*HDR_DW-1:0]     evt_hdr,
   input  logic                     reg_wr,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [31:0]              reg_wdata,
   output logic [31:0]              reg_rdata,
   output logic                     msg_valid,
   output logic [1:0]               msg_type,
   input  logic                     msg_ready
);

   generate
      if (ERR_BITS > REG_DW || (1 << CODE_W) != ERR_BITS) begin : g_bad_bits
         $error("ERR_BITS must be a power of two no larger than 32");
      end
      if ((1 << ADDR_W) < A_HLOG + HDR_DW) begin : g_bad_addr
         $error("ADDR_W too small for the header log");
      end
      if (UR_POS >= ERR_BITS || PSN_POS >= ERR_BITS || CA_POS >= ERR_BITS) begin : g_bad_pos
         $error("special error positions must lie inside ERR_BITS");
      end
   endgenerate

   ctrl_t               ctrl;
   dev_bits_t           dev_set;
   logic [ERR_BITS-1:0] c_mask, uc_mask, uc_sev, uc_stat, c_set, uc_set;
   logic                first_hit, msg_req;
   msg_kind_e           msg_kind;

   errrep_policy #(
      .ERR_BITS(ERR_BITS), .HAS_AER(HAS_AER),
      .UR_POS(UR_POS), .PSN_POS(PSN_POS), .CA_POS(CA_POS)
   ) policy_i (
      .evt_valid(evt_valid), .evt_code(evt_code), .evt_uncorr(evt_uncorr),
      .evt_fatal_dflt(evt_fatal_dflt), .ctrl(ctrl), .c_mask(c_mask),
      .uc_mask(uc_mask), .uc_sev(uc_sev), .uc_stat(uc_stat),
      .dev_set(dev_set), .c_set(c_set), .uc_set(uc_set),
      .first_hit(first_hit), .msg_req(msg_req), .msg_kind(msg_kind)
   );

   errrep_regs #(
      .ERR_BITS(ERR_BITS), .HDR_DW(HDR_DW), .ADDR_W(ADDR_W),
      .HAS_AER(HAS_AER), .NEXT_CAP(NEXT_CAP)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .dev_set(dev_set), .c_set(c_set), .uc_set(uc_set),
      .first_hit(first_hit), .first_code(evt_code), .hdr_in(evt_hdr),
      .ctrl(ctrl), .c_mask(c_mask), .uc_mask(uc_mask), .uc_sev(uc_sev),
      .uc_stat(uc_stat), .reg_rdata(reg_rdata)
   );

   errrep_msg msg_i (
      .clk(clk), .rst_n(rst_n), .req(msg_req), .kind(msg_kind),
      .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_type(msg_type)
   );

   // R6: a masked uncorrectable error raises no message
   a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_uncorr && uc_mask[evt_code] && !msg_valid) |=> !msg_valid);
   // R3: with correctable reporting off, a correctable error raises no message
   a_r3_cor_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !evt_uncorr && !ctrl.cor_en && !msg_valid) |=> !msg_valid);

endmodule

// File: tb/errrep_engine_tb.sv
module errrep_engine_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] CAP_EXP = 32'h1401_0001;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         evt_valid = 1'b0;
   logic [4:0]   evt_code = '0;
   logic         evt_uncorr = 1'b0;
   logic         evt_fatal_dflt = 1'b0;
   logic [127:0] evt_hdr = '0;
   logic         reg_wr = 1'b0;
   logic [3:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         msg_valid;
   logic [1:0]   msg_type;
   logic         msg_ready = 1'b0;

   int vecs = 0;
   int bad  = 0;
   bit done = 1'b0;

   logic [31:0] m_ctrl, m_dev, m_cs, m_cm, m_us, m_um, m_uv, m_fep;
   logic [31:0] m_hdr [4];
   bit          m_pend;
   logic [1:0]  m_type;

   always #(CLK_PERIOD/2) clk = ~clk;

   errrep_engine dut_i (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
      .evt_uncorr(evt_uncorr), .evt_fatal_dflt(evt_fatal_dflt), .evt_hdr(evt_hdr),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_type(msg_type),
      .msg_ready(msg_ready)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_reg(input int a);
      case (a)
         0: return m_ctrl;
         1: return m_dev;
         2: return m_cs;
         3: return m_cm;
         4: return m_us;
         5: return m_um;
         6: return m_uv;
         7: return m_fep;
         8: return CAP_EXP;
         9, 10, 11, 12: return m_hdr[a-9];
         default: return 32'h0;
      endcase
   endfunction

   task automatic verify_all(input string tag);
      for (int a = 0; a < 16; a++) begin
         @(negedge clk);
         reg_addr = 4'(a);
         #1;
         chk($sformatf("%s reg@%0d", tag, a), reg_rdata, exp_reg(a));
      end
   endtask

   // one clock: optional event, register write and ready, then model and check
   task automatic step(input string tag, input bit ev, input logic [4:0] code,
                       input bit unc, input logic [127:0] hdr, input bit wr,
                       input logic [3:0] addr, input logic [31:0] wd, input bit rdy);
      logic [31:0] dset, cset, uset, hot;
      bit req, fat, first;
      logic [1:0] kind;
      @(negedge clk);
      evt_valid = ev; evt_code = code; evt_uncorr = unc; evt_hdr = hdr;
      evt_fatal_dflt = 1'($urandom);
      reg_wr = wr; reg_addr = addr; reg_wdata = wd; msg_ready = rdy;
      dset = 0; cset = 0; uset = 0; req = 0; first = 0; kind = 2'b00;
      hot = 32'h1 << code;
      if (ev && !unc) begin
         dset = 32'h1; cset = hot;
         if (!m_cm[code] && m_ctrl[0]) begin req = 1; kind = 2'b00; end
      end else if (ev) begin
         fat = m_uv[code];
         dset = fat ? 32'h4 : 32'h2;
         if (code == 5'd20) dset |= 32'h8;
         if (code == 5'd12) dset |= 32'h10;
         if (code == 5'd15) dset |= 32'h20;
         uset = hot;
         if (!m_um[code]) begin
            first = (m_us == 0);
            if (code == 5'd20) begin
               if (m_ctrl[3]) begin req = 1; kind = fat ? 2'b11 : 2'b01; end
            end else begin
               if (m_ctrl[4]) dset |= 32'h40;
               if (fat && (m_ctrl[4] || m_ctrl[2])) begin req = 1; kind = 2'b11; end
               else if (!fat && (m_ctrl[4] || m_ctrl[1])) begin req = 1; kind = 2'b01; end
            end
         end
      end
      m_dev = (m_dev & ~((wr && addr == 1) ? (wd & 32'h7f) : 0)) | dset;
      m_cs  = (m_cs  & ~((wr && addr == 2) ? wd : 0)) | cset;
      m_us  = (m_us  & ~((wr && addr == 4) ? wd : 0)) | uset;
      if (wr && addr == 0) m_ctrl = wd & 32'h1f;
      if (wr && addr == 3) m_cm = wd;
      if (wr && addr == 5) m_um = wd;
      if (wr && addr == 6) m_uv = wd;
      if (first) begin
         m_fep = {27'd0, code};
         for (int i = 0; i < 4; i++) m_hdr[i] = hdr[32*i +: 32];
      end
      if (req && (!m_pend || rdy)) begin m_pend = 1; m_type = kind; end
      else if (rdy) m_pend = 0;
      @(posedge clk);
      #1;
      evt_valid = 0; reg_wr = 0; msg_ready = 0;
      chk({tag, " R10 msg_valid"}, {31'd0, msg_valid}, {31'd0, m_pend});
      if (m_pend) chk({tag, " R10 msg_type"}, {30'd0, msg_type}, {30'd0, m_type});
   endtask

   task automatic wr(input string tag, input logic [3:0] a, input logic [31:0] d);
      step(tag, 0, 0, 0, '0, 1, a, d, 0);
   endtask

   task automatic ev(input string tag, input logic [4:0] c, input bit u);
      step(tag, 1, c, u, {$urandom, $urandom, $urandom, $urandom}, 0, 0, 0, 0);
   endtask

   task automatic ack(input string tag);
      step(tag, 0, 0, 0, '0, 0, 0, 0, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_ctrl = 0; m_dev = 0; m_cs = 0; m_cm = 0; m_us = 0; m_um = 0; m_uv = 0; m_fep = 0;
      for (int i = 0; i < 4; i++) m_hdr[i] = 0;
      m_pend = 0; m_type = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 msg_valid after reset", {31'd0, msg_valid}, 32'd0);
      verify_all("R1 R12");

      // R2 R3: correctable reporting, then masked
      wr("R13", 4'd0, 32'hffff_ffff);
      verify_all("R13 ctrl width");
      wr("R13", 4'd0, 32'h1f);
      ev("R2 R3", 5'd3, 0);
      verify_all("R2");
      ack("R10");
      wr("R3", 4'd3, 32'h8);
      ev("R3 masked", 5'd3, 0);
      verify_all("R3");

      // R4 R7 R9: first error capture, later error keeps log
      wr("R4", 4'd6, 32'h80);
      ev("R4 R9 fatal", 5'd7, 1);
      verify_all("R4 R7");
      ack("R10");
      ev("R9 nonfatal", 5'd9, 1);
      verify_all("R7 second");
      ack("R10");

      // R6: masked error after clearing status
      wr("R11", 4'd4, 32'hffff_ffff);
      wr("R11", 4'd1, 32'hffff_ffff);
      wr("R6", 4'd5, 32'h200);
      ev("R6 masked", 5'd9, 1);
      verify_all("R6");

      // R5 R8: unsupported request paths and special codes
      wr("R8", 4'd0, 32'h17);
      wr("R11", 4'd4, 32'hffff_ffff);
      ev("R8 UR off", 5'd20, 1);
      verify_all("R5 R8");
      wr("R8", 4'd0, 32'h08);
      wr("R8", 4'd6, 32'h0010_0000);
      ev("R8 UR fatal", 5'd20, 1);
      ack("R10");
      ev("R5 poison", 5'd12, 1);
      ev("R5 abort", 5'd15, 1);
      verify_all("R5");

      // R11: same-cycle set and clear
      step("R11 dev", 1, 5'd1, 0, '0, 1, 4'd1, 32'hffff_ffff, 0);
      step("R11 cstat", 1, 5'd1, 0, '0, 1, 4'd2, 32'hffff_ffff, 0);
      verify_all("R11");

      // R10: drop while pending, take on same-cycle accept
      wr("R10", 4'd0, 32'h1f);
      wr("R10", 4'd3, 32'h0);
      wr("R10", 4'd5, 32'h0);
      wr("R10", 4'd6, 32'h0);
      ev("R10 first", 5'd0, 0);
      ev("R10 dropped", 5'd5, 1);
      step("R10 swap", 1, 5'd6, 1, '0, 0, 0, 0, 1);
      ack("R10");

      // R13: random mix of events, writes and accepts
      for (int n = 0; n < 800; n++) begin
         logic [4:0] c;
         int pick;
         pick = $urandom_range(0, 5);
         c = (pick == 0) ? 5'd20 : (pick == 1) ? 5'd12 : (pick == 2) ? 5'd15 : 5'($urandom);
         step("R13 random", 1'($urandom_range(0, 3) != 0), c, 1'($urandom),
              {$urandom, $urandom, $urandom, $urandom},
              1'($urandom_range(0, 2) == 0), 4'($urandom_range(0, 6)),
              ($urandom_range(0, 1) == 0) ? $urandom : (32'h1 << $urandom_range(0, 31)),
              1'($urandom_range(0, 2) == 0));
         if (n % 40 == 39) verify_all("R13 random");
      end
      verify_all("R13 final");

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

endmodule